// File: doc/BRIEF.md
# Basic Interval Timer with Watchdog

This block divides the system clock down to a slow tick and uses that tick for two 8-bit counters. The first counter runs freely. Each time it rolls over from its top value back to zero, it raises a one-cycle interrupt pulse, which gives software a steady periodic event. The second counter is a watchdog. While it is enabled it climbs on the same ticks. It stops at its top value, and once it is there it raises a reset request that stays high until the block is reset.

The watchdog count is not a separate register. It sits in bits 15:8 of the control word, next to the tick-rate select in bits 3:2 and the enable in bit 16. Software keeps the system alive by rewriting the control word with zero in the count field. Every control write also restarts the clock divider, so the first tick after a write always lands a full period later. Reading the control word shows the live watchdog count.

The number of clocks per tick is 2^(MAX_EXP − s), where s is the 2-bit select. With the default MAX_EXP of 13 this gives 8192, 4096, 2048 or 1024 clocks per tick.

Top module: `beat_watchdog`

## Requirements
- R1: After reset, the read word is zero, the basic count is zero, and both the interrupt and the reset request are low.
- R2: Ticks occur every 2^(MAX_EXP − s) clocks, where s is control bits 3:2. A control write cancels any tick in its own cycle and restarts the divider, so the first counter update after the write edge happens exactly one period of clock edges later.
- R3: The basic count advances by one on each tick. From 0xFF the next tick takes it to 0x00.
- R4: The interrupt output is high for exactly the one cycle in which the basic count first shows 0x00 after a wrap, and is low at all other times.
- R5: While control bit 16 is 1, the watchdog count advances by one on each tick. While bit 16 is 0, the count holds its value.
- R6: The watchdog count stays at 0xFF and never wraps.
- R7: The reset request rises one clock after the watchdog count is 0xFF with bit 16 set. It then stays high, even through later control writes, until the reset input is applied.
- R8: A control write loads the select from bits 3:2, the watchdog count from bits 15:8 and the enable from bit 16. Writing zero in bits 15:8 restarts the watchdog from zero.
- R9: The read word holds the select in bits 3:2, the live watchdog count in bits 15:8 and the enable in bit 16. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word read value, including the live watchdog count |
| bt_count | output | BT_W | Current basic count |
| bt_irq | output | 1 | One-cycle pulse on each basic-counter wrap |
| wdt_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The hardest state to reach from the ports is a watchdog that is one tick away from expiry, or already expired, while the basic counter is partway through a wrap. The bench reaches it in three ways. It loads the count field with values close to full scale (0xFE and 0xFF) instead of waiting hundreds of ticks. It builds the design with a small MAX_EXP so that a full 256-tick sweep takes only a few thousand clocks at every select value. It issues repeated kicks at fixed tick counts, so the divider restart and the survival of the basic count across writes are checked again and again against a closed-form count of ticks since the last write.

// File: rtl/bw_pkg.sv
package bw_pkg;
   // Control word field layout (positions are decoded by software).
   localparam int CTRL_W  = 32;
   localparam int SEL_LSB = 2;
   localparam int SEL_W   = 2;
   localparam int WD_LSB  = 8;
   localparam int WD_W    = 8;
   localparam int EN_BIT  = 16;

   typedef struct packed {
      logic             en;
      logic [WD_W-1:0]  wd;
      logic [SEL_W-1:0] sel;
   } ctrl_fields_t;

   function automatic ctrl_fields_t unpack_ctrl(input logic [CTRL_W-1:0] w);
      ctrl_fields_t f;
      f.en  = w[EN_BIT];
      f.wd  = w[WD_LSB +: WD_W];
      f.sel = w[SEL_LSB +: SEL_W];
      return f;
   endfunction

   function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_fields_t f);
      logic [CTRL_W-1:0] w;
      w                    = '0;
      w[EN_BIT]            = f.en;
      w[WD_LSB +: WD_W]    = f.wd;
      w[SEL_LSB +: SEL_W]  = f.sel;
      return w;
   endfunction
endpackage

// File: rtl/bw_divider.sv
module bw_divider #(
   parameter int MAX_EXP = 13,
   parameter int SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int SEL_N = 1 << SEL_W;

   logic [MAX_EXP-1:0] limit [SEL_N];
   logic [MAX_EXP-1:0] pre_q;

   // One terminal value per select code: 2^(MAX_EXP-g) - 1.
   for (genvar g = 0; g < SEL_N; g++) begin : g_limit
      assign limit[g] = MAX_EXP'((64'd1 << (MAX_EXP - g)) - 64'd1);
   end

   assign tick = !restart && (pre_q == limit[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pre_q <= '0;
      else if (restart || tick) pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
   end

   p_restart_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);
   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/bw_wrap_counter.sv
module bw_wrap_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   output logic [W-1:0] count,
   output logic         wrap_pulse
);
   logic at_top;
   assign at_top = (count == {W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count      <= '0;
         wrap_pulse <= 1'b0;
      end else begin
         wrap_pulse <= tick && at_top;
         if (tick) count <= count + 1'b1;
      end
   end

   p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_top) |=> (count == '0) && wrap_pulse);
   p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |=> !wrap_pulse);
   p_irq_only_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |-> (count == '0));
endmodule

// File: rtl/bw_guard.sv
module bw_guard #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         rst_req
);
   logic full;
   assign full = (count == {W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= rst_req || (en && full);
         if (load)                    count <= load_val;
         else if (en && tick && !full) count <= count + 1'b1;
      end
   end

   p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(count));
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !load) |=> full);
   p_request_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);
   p_request_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && full) |=> rst_req);
endmodule

// File: rtl/beat_watchdog.sv
module beat_watchdog
   import bw_pkg::*;
#(
   parameter int MAX_EXP = 13,
   parameter int BT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [31:0]       ctrl_wdata,
   output logic [31:0]       ctrl_rdata,
   output logic [BT_W-1:0]   bt_count,
   output logic              bt_irq,
   output logic              wdt_rst_req
);
   localparam int MIN_EXP = MAX_EXP - ((1 << SEL_W) - 1);

   if (MIN_EXP < 1) begin : g_bad_exp
      $error("beat_watchdog: MAX_EXP too small for a tick period of at least 2");
   end
   if (MAX_EXP > 31) begin : g_big_exp
      $error("beat_watchdog: MAX_EXP must not exceed 31");
   end
   if (BT_W < 2) begin : g_bad_bt
      $error("beat_watchdog: BT_W must be at least 2");
   end

   ctrl_fields_t     wr_f;
   logic [SEL_W-1:0] sel_q;
   logic             en_q;
   logic [WD_W-1:0]  wd_count;
   logic             tick;
   logic             unused_wbits;

   assign wr_f         = unpack_ctrl(ctrl_wdata);
   assign unused_wbits = ^{ctrl_wdata[31:17], ctrl_wdata[7:4], ctrl_wdata[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= 1'b0;
      end else if (ctrl_we) begin
         sel_q <= wr_f.sel;
         en_q  <= wr_f.en;
      end
   end

   bw_divider #(.MAX_EXP(MAX_EXP), .SEL_W(SEL_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctrl_we),
      .sel     (sel_q),
      .tick    (tick)
   );

   bw_wrap_counter #(.W(BT_W)) u_bt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .count      (bt_count),
      .wrap_pulse (bt_irq)
   );

   bw_guard #(.W(WD_W)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .en       (en_q),
      .load     (ctrl_we),
      .load_val (wr_f.wd),
      .count    (wd_count),
      .rst_req  (wdt_rst_req)
   );

   always_comb begin
      ctrl_fields_t rd_f;
      rd_f.en    = en_q;
      rd_f.wd    = wd_count;
      rd_f.sel   = sel_q;
      ctrl_rdata = pack_ctrl(rd_f);
   end

   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (ctrl_rdata[15:8] == $past(ctrl_wdata[15:8])));
   p_readback_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[31:17] == '0) && (ctrl_rdata[7:4] == '0) && (ctrl_rdata[1:0] == '0));
endmodule

// File: tb/beat_watchdog_tb.sv
module beat_watchdog_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MAXE       = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic [31:0] ctrl_rdata;
   logic [7:0]  bt_count;
   logic        bt_irq;
   logic        wdt_rst_req;

   int vecs = 0;
   int errs = 0;
   int cnt_m = 0;  // bench-tracked basic count

   beat_watchdog #(.MAX_EXP(MAXE), .BT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .bt_count(bt_count), .bt_irq(bt_irq),
      .wdt_rst_req(wdt_rst_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      errs++;
      $display("FAIL watchdog timeout: act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctrl_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cnt_m = 0;
   endtask

   function automatic logic [31:0] word(input int en, input int wd, input int sel);
      return (32'(en) << 16) | (32'(wd & 255) << 8) | (32'(sel & 3) << 2);
   endfunction

   // Must be called at a negedge; returns at the negedge after the write edge.
   task automatic wr(input logic [31:0] d);
      ctrl_we = 1'b1; ctrl_wdata = d;
      @(negedge clk);
      ctrl_we = 1'b0; ctrl_wdata = '0;
   endtask

   // Check n cycles after a write of (en, wd0, sel); rst0 is the request state before.
   task automatic run(input int n, input int en, input int wd0, input int sel, input int rst0);
      int per = 1 << (MAXE - sel);
      int c0  = cnt_m;
      for (int k = 1; k <= n; k++) begin
         int ticks, ecnt, ewd, eirq, erst;
         @(negedge clk);
         ticks = k / per;
         ecnt  = (c0 + ticks) % 256;
         eirq  = (k % per == 0 && ticks > 0 && ecnt == 0) ? 1 : 0;
         ewd   = en != 0 ? ((wd0 + ticks > 255) ? 255 : wd0 + ticks) : wd0;
         erst  = (rst0 != 0 || (en != 0 && k >= per * (255 - wd0) + 1)) ? 1 : 0;
         chk("R2/R3 basic count", 32'(bt_count), 32'(ecnt));
         chk("R4 irq", 32'(bt_irq), 32'(eirq));
         chk("R5/R6/R9 read word", ctrl_rdata, word(en, ewd, sel));
         chk("R7 reset request", 32'(wdt_rst_req), 32'(erst));
         cnt_m = ecnt;
      end
   endtask

   initial begin
      do_reset();
      // R1: reset state
      chk("R1 read word", ctrl_rdata, 32'h0);
      chk("R1 count", 32'(bt_count), 32'h0);
      chk("R1 irq", 32'(bt_irq), 32'h0);
      chk("R1 request", 32'(wdt_rst_req), 32'h0);

      // R2 R3 R4 R5 R6 R7: full sweep at every select value
      for (int s = 0; s < 4; s++) begin
         do_reset();
         wr(word(1, 0, s));
         run(257 * (1 << (MAXE - s)), 1, 0, s, 0);
      end

      // R8: periodic kicks keep the request low; count carries across writes
      do_reset();
      for (int r = 0; r < 4; r++) begin
         wr(word(1, 0, 2));
         run(200 * 8, 1, 0, 2, 0);
      end

      // R5: disabled watchdog holds a loaded value
      wr(word(0, 16, 1));
      run(40 * 16, 0, 16, 1, 0);

      // R6 R7: load near full scale
      wr(word(1, 254, 3));
      run(4 * 4, 1, 254, 3, 0);

      // R7: sticky through disabling writes
      wr(word(0, 0, 3));
      run(3 * 4, 0, 0, 3, 1);

      // R7: full-scale load fires one clock after
      do_reset();
      wr(word(1, 255, 0));
      run(5, 1, 255, 0, 0);

      // R9: all-ones write reads back only the defined fields
      do_reset();
      wr(32'hFFFF_FFFF);
      chk("R9 readback mask", ctrl_rdata, 32'h0001_FF0C);

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule